// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Load Strobe

This block is a FIFO that links two unrelated clock domains. The write port stores 36-bit words under an active-low write enable. The read port runs in fall-through mode. When a word enters an empty FIFO, it moves into the read-side output register without any read request, and an active-low ready flag announces it. After that, each enabled read-clock edge replaces the held word with the next stored word. The ready flag also drops back to inactive when the held word is consumed and no further word is waiting.

Alongside the data, the read side drives an active-low load strobe. The strobe is low for exactly those read cycles that follow a load of a fresh word into the output register, and the automatic fall-through counts as a load. Downstream logic can therefore count words without decoding the ready flag. The visible output bus is gated by a read chip select and an output enable. Both must be low for the held word to appear. Otherwise the bus is parked at zero and marked undriven. The chip select never advances the FIFO. Pointers cross between the domains in Gray code, and the storage depth is a power of two chosen by a parameter.

Top module: `fwft_echo_fifo`

## Requirements
- R1: While either reset is high and on the first cycle after it, `ready_n` and `echo_n` are 1, `wr_full` is 0 and `q_bus` is 0.
- R2: A word written into an empty FIFO reaches the output register with no read request, and `ready_n` then goes to 0.
- R3: `echo_n` is 0 in exactly the read cycles that follow a load of a new word into the output register, including the fall-through load, and is 1 in every other read cycle.
- R4: `q_bus` shows the output register and `bus_on` is 1 only while `rd_cs_n` and `out_en_n` are both 0. Otherwise `q_bus` is 0 and `bus_on` is 0.
- R5: While `rd_en_n` is 1, the held word stays in the output register, `ready_n` stays 0 and `echo_n` is 1, whatever the state of `rd_cs_n`.
- R6: Each read-clock edge with `rd_en_n` at 0 and a word waiting loads the next word in write order. During back-to-back reads that each deliver a word, `echo_n` stays 0.
- R7: The first enabled read after the last stored word has been moved out sets `ready_n` and `echo_n` to 1.
- R8: `rd_en_n` at 0 while `ready_n` is 1 and nothing is stored changes nothing. A later write still falls through intact.
- R9: The FIFO holds 2^ADDR_W words in storage plus one in the output register. `wr_full` goes to 1 once storage is full, and writes while `wr_full` is 1 are dropped.
- R10: After a full condition, every accepted word is read back in write order, and `wr_full` returns to 0 once reads have freed space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Storage full, registered in the write domain |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_n | input | 1 | Active-low read enable |
| rd_cs_n | input | 1 | Active-low read chip select, gates the bus only |
| out_en_n | input | 1 | Active-low output enable |
| q_bus | output | DATA_W | Output register contents when enabled, else 0 |
| bus_on | output | 1 | 1 when `q_bus` carries the output register |
| ready_n | output | 1 | Active-low: output register holds a valid word |
| echo_n | output | 1 | Active-low: a new word was loaded on the last read edge |

## Verification
A written word needs one write edge, then two read edges of synchronization, then one more read edge to fall through. The bench therefore polls `ready_n` on falling read edges for a bounded window, and checks `echo_n` low in the same sample where ready first appears and high one sample later. An enabled read takes effect on the next rising read edge. Each read check drives `rd_en_n` on a falling edge and compares data, ready and strobe on the following falling edge. `wr_full` is registered on the write edge that takes the last free slot and is checked two write cycles later. The bus gating is combinational, so it is sampled one time unit after its controls change.

// File: rtl/fwft_fifo_pkg.sv
package fwft_fifo_pkg;
  localparam int FIFO_DATA_W = 36;
  localparam int FIFO_ADDR_W = 10;
  localparam int SYNC_STAGES = 2;

  // Whether the read-side output register holds a valid word.
  typedef enum logic {
    OREG_EMPTY = 1'b0,
    OREG_FULL  = 1'b1
  } oreg_state_e;
endpackage

// File: rtl/fwft_sync.sv
module fwft_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= '0;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/fwft_ram.sv
module fwft_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with enable: this register is the output register.
  always_ff @(posedge rd_clk) begin
    if (rd_rst)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fwft_wr_ctrl.sv
module fwft_wr_ctrl #(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en_n,
  input  logic [PTR_W-1:0]  rd_gray_sync,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic [PTR_W-1:0]  wr_bin,
  output logic              wr_full
);
  localparam logic [PTR_W-1:0] FULL_FLIP = {2'b11, {(PTR_W-2){1'b0}}};

  logic [PTR_W-1:0] wr_bin_nxt;
  logic [PTR_W-1:0] wr_gray_nxt;
  logic             full_nxt;

  always_comb begin
    we          = !wr_en_n && !wr_full;
    wr_bin_nxt  = wr_bin + PTR_W'(we);
    wr_gray_nxt = wr_bin_nxt ^ (wr_bin_nxt >> 1);
    full_nxt    = (wr_gray_nxt == (rd_gray_sync ^ FULL_FLIP));
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wr_bin  <= '0;
      wr_gray <= '0;
      wr_full <= 1'b0;
    end else begin
      wr_bin  <= wr_bin_nxt;
      wr_gray <= wr_gray_nxt;
      wr_full <= full_nxt;
    end
  end

  assign waddr = wr_bin[ADDR_W-1:0];
endmodule

// File: rtl/fwft_rd_ctrl.sv
module fwft_rd_ctrl
  import fwft_fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en_n,
  input  logic [PTR_W-1:0]  wr_gray_sync,
  output logic              load,
  output logic [ADDR_W-1:0] raddr,
  output logic [PTR_W-1:0]  rd_gray,
  output logic              ready_n,
  output logic              echo_n
);
  oreg_state_e      state_q;
  logic [PTR_W-1:0] rd_bin_q;
  logic [PTR_W-1:0] rd_bin_nxt;
  logic             words_waiting;
  logic             want_word;

  always_comb begin
    words_waiting = (rd_gray != wr_gray_sync);
    want_word     = (state_q == OREG_EMPTY) || !rd_en_n;
    load          = words_waiting && want_word;
    rd_bin_nxt    = rd_bin_q + PTR_W'(load);
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rd_bin_q <= '0;
      rd_gray  <= '0;
      state_q  <= OREG_EMPTY;
      echo_n   <= 1'b1;
    end else begin
      rd_bin_q <= rd_bin_nxt;
      rd_gray  <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
      echo_n   <= !load;
      if (load)          state_q <= OREG_FULL;
      else if (!rd_en_n) state_q <= OREG_EMPTY;
    end
  end

  assign raddr   = rd_bin_q[ADDR_W-1:0];
  assign ready_n = (state_q == OREG_EMPTY);
endmodule

// File: rtl/fwft_echo_fifo.sv
module fwft_echo_fifo
  import fwft_fifo_pkg::*;
#(
  parameter int DATA_W = FIFO_DATA_W,
  parameter int ADDR_W = FIFO_ADDR_W,
  parameter int STAGES = SYNC_STAGES,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en_n,
  input  logic              rd_cs_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] q_bus,
  output logic              bus_on,
  output logic              ready_n,
  output logic              echo_n
);
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [PTR_W-1:0]  wr_gray;
  logic [PTR_W-1:0]  wr_bin;
  logic [PTR_W-1:0]  wr_gray_sync;
  logic              load;
  logic [ADDR_W-1:0] raddr;
  logic [PTR_W-1:0]  rd_gray;
  logic [PTR_W-1:0]  rd_gray_sync;
  logic [DATA_W-1:0] oreg_q;

  fwft_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en_n(wr_en_n),
    .rd_gray_sync(rd_gray_sync), .we(we), .waddr(waddr),
    .wr_gray(wr_gray), .wr_bin(wr_bin), .wr_full(wr_full)
  );

  fwft_sync #(.W(PTR_W), .STAGES(STAGES)) u_rd2wr (
    .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rd_gray_sync)
  );

  fwft_sync #(.W(PTR_W), .STAGES(STAGES)) u_wr2rd (
    .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wr_gray_sync)
  );

  fwft_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en_n(rd_en_n),
    .wr_gray_sync(wr_gray_sync), .load(load), .raddr(raddr),
    .rd_gray(rd_gray), .ready_n(ready_n), .echo_n(echo_n)
  );

  fwft_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .re(load), .raddr(raddr),
    .rdata(oreg_q)
  );

  always_comb begin
    bus_on = !rd_cs_n && !out_en_n;
    q_bus  = bus_on ? oreg_q : '0;
  end
endmodule

// File: rtl/fwft_echo_fifo_chk.sv
module fwft_echo_fifo_chk #(
  parameter int DATA_W = 36,
  parameter int PTR_W  = 11
) (
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en_n,
  input logic              ready_n,
  input logic              echo_n,
  input logic [DATA_W-1:0] oreg_q,
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              wr_en_n,
  input logic              wr_full,
  input logic [PTR_W-1:0]  wr_bin
);
  // R3: a load strobe only ever accompanies a valid held word.
  p_echo_with_word_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !echo_n |-> !ready_n);

  // R2: leaving the empty state is always flagged by the strobe.
  p_fall_through_r2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    ready_n |=> (echo_n == ready_n));

  // R5: no read enable, held word and flags unchanged.
  p_hold_word_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!ready_n && rd_en_n) |=> (echo_n && !ready_n && $stable(oreg_q)));

  // R6: an enabled read of a held word either loads a new one or empties.
  p_read_moves_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!ready_n && !rd_en_n) |=> (!echo_n || ready_n));

  // R7: becoming empty never coincides with a load.
  p_drain_quiet_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $rose(ready_n) |-> echo_n);

  // R9: a write while full does not move the write pointer.
  p_no_overflow_r9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_full && !wr_en_n) |=> $stable(wr_bin));
endmodule

bind fwft_echo_fifo fwft_echo_fifo_chk #(.DATA_W(DATA_W), .PTR_W(ADDR_W + 1)) u_chk (
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en_n(rd_en_n), .ready_n(ready_n),
  .echo_n(echo_n), .oreg_q(oreg_q), .wr_clk(wr_clk), .wr_rst(wr_rst),
  .wr_en_n(wr_en_n), .wr_full(wr_full), .wr_bin(wr_bin)
);

// File: tb/fwft_echo_fifo_bench.sv
module fwft_echo_fifo_bench;
  localparam int DW    = 36;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_rst = 1'b1;
  logic          rd_rst = 1'b1;
  logic          wr_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic          wr_full;
  logic          rd_en_n = 1'b1;
  logic          rd_cs_n = 1'b1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] q_bus;
  logic          bus_on;
  logic          ready_n;
  logic          echo_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #4 rd_clk = ~rd_clk;
  end

  fwft_echo_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_fwft_echo_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en_n(rd_en_n),
    .rd_cs_n(rd_cs_n), .out_en_n(out_en_n), .q_bus(q_bus), .bus_on(bus_on),
    .ready_n(ready_n), .echo_n(echo_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = v;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_wait(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  // Read n held words back to back, expecting base+i in order.
  task automatic drain(input logic [DW-1:0] base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(!ready_n, req, "ready before read", DW'(ready_n), '0);
      check(q_bus == base + DW'(i), req, "word order", q_bus, base + DW'(i));
      rd_en_n = 1'b0;
      @(negedge rd_clk);
      if (i < n - 1)
        check(!echo_n, "R6", "strobe on back-to-back read", DW'(echo_n), '0);
      else begin
        check(echo_n, "R7", "strobe after last word", DW'(echo_n), 1);
        check(ready_n, "R7", "ready after last word", DW'(ready_n), 1);
      end
    end
    rd_en_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge rd_clk);
    check(ready_n, "R1", "ready in reset", DW'(ready_n), 1);
    check(echo_n, "R1", "strobe in reset", DW'(echo_n), 1);
    check(!wr_full, "R1", "full in reset", DW'(wr_full), 0);
    @(negedge wr_clk);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    @(negedge rd_clk);
    check(ready_n && echo_n, "R1", "flags after reset", {34'd0, ready_n, echo_n}, 2'b11);
    rd_cs_n = 1'b0;
    #1;
    check(q_bus == '0, "R1", "cleared output register", q_bus, '0);
    rd_cs_n = 1'b1;
  endtask

  task automatic t_fall_through();
    bit seen = 0;
    put(36'hA_0000_0001);
    for (int k = 0; k < 10 && !seen; k++) begin
      @(negedge rd_clk);
      if (!ready_n) seen = 1;
      else check(echo_n, "R3", "strobe while empty", DW'(echo_n), 1);
    end
    check(seen, "R2", "fall through without read", DW'(seen), 1);
    check(!echo_n, "R3", "strobe on fall through", DW'(echo_n), 0);
    @(negedge rd_clk);
    check(echo_n, "R3", "strobe one cycle only", DW'(echo_n), 1);
    check(!bus_on && q_bus == '0, "R4", "bus off, cs high", q_bus, '0);
    rd_cs_n = 1'b0; out_en_n = 1'b1;
    #1;
    check(!bus_on && q_bus == '0, "R4", "bus off, oe high", q_bus, '0);
    out_en_n = 1'b0;
    #1;
    check(bus_on && q_bus == 36'hA_0000_0001, "R4", "bus on", q_bus, 36'hA_0000_0001);
    rd_wait(3);
    check(!ready_n && echo_n, "R5", "held with cs low", {34'd0, ready_n, echo_n}, 2'b01);
    check(q_bus == 36'hA_0000_0001, "R5", "word held", q_bus, 36'hA_0000_0001);
  endtask

  task automatic t_stream();
    put(36'hA_0000_0002);
    put(36'hA_0000_0003);
    put(36'hA_0000_0004);
    rd_wait(8);
    check(echo_n, "R5", "no strobe while reads idle", DW'(echo_n), 1);
    drain(36'hA_0000_0001, 4, "R6");
  endtask

  task automatic t_idle_read();
    rd_en_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge rd_clk);
      check(ready_n && echo_n, "R8", "read while empty", {34'd0, ready_n, echo_n}, 2'b11);
    end
    rd_en_n = 1'b1;
    put(36'hB_0000_0055);
    rd_wait(8);
    check(!ready_n, "R8", "later write falls through", DW'(ready_n), 0);
    check(q_bus == 36'hB_0000_0055, "R8", "later word intact", q_bus, 36'hB_0000_0055);
    drain(36'hB_0000_0055, 1, "R8");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) put(36'hC_0000_0000 + DW'(i));
    rd_wait(12);
    check(!wr_full, "R9", "not full with one slot left", DW'(wr_full), 0);
    put(36'hC_0000_0000 + DW'(DEPTH));
    @(negedge wr_clk);
    check(wr_full, "R9", "full after depth plus one", DW'(wr_full), 1);
    for (int j = 0; j < 3; j++) put(36'hD_EAD0_0000 + DW'(j));
    rd_wait(4);
    drain(36'hC_0000_0000, DEPTH + 1, "R10");
    rd_wait(4);
    @(negedge wr_clk);
    check(!wr_full, "R10", "full clears after reads", DW'(wr_full), 0);
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge wr_clk);
    t_reset();
    t_fall_through();
    t_stream();
    t_idle_read();
    t_full();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule